// File: doc/BRIEF.md
# Descriptor Ring Register Bank

This block decodes a window of memory-mapped registers that the host uses to set up descriptor rings. The window is cut into equal slices, one per ring. The ring set is fixed: a command ring, an event ring, and then one transmit ring and one receive ring for each port, interleaved port by port. Each slice holds the ring's 64-bit base address, size, head, tail, a control word and a count of outstanding credits. Reads are combinational from the address. Writes take effect at the clock edge.

The device side posts completed descriptors through a simple strobe. A post advances the ring's tail, which wraps at the ring size, and adds one credit. The host returns credits by writing the credit register. A head write that leaves work pending raises an interrupt request on the vector tied to that ring. A credit return that still leaves credits outstanding does the same. A separate request input lets other logic raise any vector. Requests at or above the vector count are dropped.

Top module: `ring_reg_bank`

## Requirements
- R1: Only addresses from WIN_BASE up to but not including WIN_BASE + rings × 2^SLICE_SHIFT are decoded. Outside this window reads return 0 and writes change nothing.
- R2: Ring r owns the slice starting at WIN_BASE + r × 2^SLICE_SHIFT. Ring 0 is command, ring 1 is event, ring 2+2k is port k transmit and ring 3+2k is port k receive. A write to one ring never changes another ring. A 32-bit read returns zero in bits 63:32.
- R3: A 32-bit write at slice offset 0x00 only loads one staging word shared by all rings. A 32-bit write at offset 0x04 sets that ring's base to {written value, staging word} and clears the staging word. 32-bit reads at 0x00 and 0x04 return the low and high halves of the base.
- R4: A 64-bit write at offset 0x00 sets the whole base in one access and leaves the staging word alone. A 64-bit read there returns the whole base.
- R5: Offsets 0x08 (size), 0x0C (head) and 0x14 (control) read back what was written. Offset 0x10 (tail) is read-only, and writing it has no effect.
- R6: A device post to ring r advances its tail by one, wrapping to 0 when the result would reach the size (a size of 0 keeps the tail at 0). The post also adds one credit, readable at offset 0x18.
- R7: Writing offset 0x18 subtracts the value from the outstanding credits, stopping at zero. An interrupt request follows when credits remain after the subtraction.
- R8: A head write raises an interrupt request when the new head differs from the ring's tail, and raises none when it equals the tail.
- R9: The vector of ring r is r for the command and event rings and r+1 for the others (vector 2 is never used by a ring). The request appears as a one-cycle irqValid pulse with irqVector in the cycle after the write.
- R10: An external request with a vector below 3 + 2 × NUM_PORTS is issued one cycle later. A request at or above that count is dropped. A ring request in the same cycle wins over an external one.
- R11: Offsets other than those listed read 0, and writes to them are ignored. 64-bit accesses at any offset other than 0x00 read 0 and write nothing.
- R12: After reset every ring register, the staging word and irqValid are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe for the current address |
| busWide | input | 1 | 1 selects a 64-bit access, 0 a 32-bit access |
| busAddr | input | ADDR_W | Byte address |
| busWrData | input | 64 | Write data (bits 31:0 used by 32-bit writes) |
| busRdData | output | 64 | Combinational read data for busAddr |
| postEn | input | 1 | Device has completed one descriptor |
| postRing | input | 8 | Ring index of the posted descriptor |
| extIrqEn | input | 1 | External interrupt request strobe |
| extIrqVec | input | 8 | Vector of the external request |
| irqValid | output | 1 | Interrupt request pulse |
| irqVector | output | 8 | Vector of the request |

## Verification
The bench stages a low half on one ring and commits the high half on another. A design that kept a staging word per ring, or never cleared it, would build the wrong base. It returns more credits than are outstanding and expects zero and no interrupt, where a wrapping subtract would leave a huge count and fire. It writes head equal to tail and then different from it, and it drives posts across the size boundary to catch an off-by-one tail wrap. It also probes addresses just outside the window, the read-only tail, 64-bit accesses at narrow offsets, external vectors on both sides of the limit, and a collision between a ring request and an external one. A design with a wrong vector map or priority would report the wrong vector.

// File: rtl/ringbank_pkg.sv
package ringbank_pkg;
  localparam int RING_IDX_W = 8;

  localparam logic [7:0] OFF_BASE_LO = 8'h00;
  localparam logic [7:0] OFF_BASE_HI = 8'h04;
  localparam logic [7:0] OFF_SIZE    = 8'h08;
  localparam logic [7:0] OFF_HEAD    = 8'h0C;
  localparam logic [7:0] OFF_TAIL    = 8'h10;
  localparam logic [7:0] OFF_CTRL    = 8'h14;
  localparam logic [7:0] OFF_CREDIT  = 8'h18;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_BASE_LO, SEL_BASE_HI, SEL_BASE64,
    SEL_SIZE, SEL_HEAD, SEL_TAIL, SEL_CTRL, SEL_CREDIT
  } rdSel_e;

  typedef struct packed {
    logic wrBaseLo;
    logic wrBaseHi;
    logic wrBase64;
    logic wrSize;
    logic wrHead;
    logic wrCtrl;
    logic wrCredit;
    rdSel_e rdSel;
    logic [RING_IDX_W-1:0] ring;
  } ringStb_t;

  // command and event rings keep their index, vector 2 is skipped
  function automatic logic [7:0] vectorOf(input logic [7:0] ring);
    return (ring < 8'd2) ? ring : ring + 8'd1;
  endfunction
endpackage

// File: rtl/ring_reg_ctrl.sv
module ring_reg_ctrl
  import ringbank_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int WIN_BASE    = 4096,
  parameter int SLICE_SHIFT = 5,
  parameter int RINGS       = 6,
  parameter int VEC_COUNT   = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busWide,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              ringReq,
  input  logic [7:0]        ringVec,
  input  logic              extIrqEn,
  input  logic [7:0]        extIrqVec,
  output ringStb_t          stb,
  output logic              irqValid,
  output logic [7:0]        irqVector
);
  localparam int WIN_END = WIN_BASE + RINGS * (1 << SLICE_SHIFT);

  logic              inWin;
  logic [ADDR_W-1:0] relAddr;
  logic [7:0]        ringIdx;
  logic [7:0]        off;

  assign inWin   = ({1'b0, busAddr} >= (ADDR_W+1)'(WIN_BASE)) &&
                   ({1'b0, busAddr} <  (ADDR_W+1)'(WIN_END));
  assign relAddr = busAddr - ADDR_W'(WIN_BASE);
  assign ringIdx = 8'(relAddr >> SLICE_SHIFT);
  assign off     = 8'(relAddr[SLICE_SHIFT-1:0]);

  always_comb begin
    stb       = '0;
    stb.rdSel = SEL_NONE;
    stb.ring  = ringIdx;
    if (inWin) begin
      case (off)
        OFF_BASE_LO: begin
          stb.rdSel    = busWide ? SEL_BASE64 : SEL_BASE_LO;
          stb.wrBase64 = busWrEn && busWide;
          stb.wrBaseLo = busWrEn && !busWide;
        end
        OFF_BASE_HI: if (!busWide) begin
          stb.rdSel    = SEL_BASE_HI;
          stb.wrBaseHi = busWrEn;
        end
        OFF_SIZE: if (!busWide) begin
          stb.rdSel  = SEL_SIZE;
          stb.wrSize = busWrEn;
        end
        OFF_HEAD: if (!busWide) begin
          stb.rdSel  = SEL_HEAD;
          stb.wrHead = busWrEn;
        end
        OFF_TAIL: if (!busWide) stb.rdSel = SEL_TAIL;
        OFF_CTRL: if (!busWide) begin
          stb.rdSel  = SEL_CTRL;
          stb.wrCtrl = busWrEn;
        end
        OFF_CREDIT: if (!busWide) begin
          stb.rdSel    = SEL_CREDIT;
          stb.wrCredit = busWrEn;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqValid  <= 1'b0;
      irqVector <= '0;
    end else if (ringReq) begin
      irqValid  <= 1'b1;
      irqVector <= ringVec;
    end else if (extIrqEn && (extIrqVec < 8'(VEC_COUNT))) begin
      irqValid  <= 1'b1;
      irqVector <= extIrqVec;
    end else begin
      irqValid  <= 1'b0;
    end
  end
endmodule

// File: rtl/ring_reg_dp.sv
module ring_reg_dp
  import ringbank_pkg::*;
#(
  parameter int RINGS = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  ringStb_t    stb,
  input  logic [63:0] wrData,
  input  logic        postEn,
  input  logic [7:0]  postRing,
  output logic [63:0] rdData,
  output logic        ringReq,
  output logic [7:0]  ringVec
);
  localparam int RIW = (RINGS > 1) ? $clog2(RINGS) : 1;

  logic [63:0] baseQ   [RINGS];
  logic [31:0] sizeQ   [RINGS];
  logic [31:0] headQ   [RINGS];
  logic [31:0] tailQ   [RINGS];
  logic [31:0] ctrlQ   [RINGS];
  logic [31:0] credQ   [RINGS];
  logic [31:0] credNext[RINGS];
  logic [31:0] stageQ;
  logic [RIW-1:0] sel;

  assign sel = stb.ring[RIW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN)             stageQ <= '0;
    else if (stb.wrBaseLo) stageQ <= wrData[31:0];
    else if (stb.wrBaseHi) stageQ <= '0;
  end

  for (genvar g = 0; g < RINGS; g++) begin : gRing
    logic        hitW;
    logic        postHit;
    logic [31:0] credPlus;
    logic [32:0] tailInc;

    assign hitW    = (stb.ring == 8'(g));
    assign postHit = postEn && (postRing == 8'(g));
    assign tailInc = {1'b0, tailQ[g]} + 33'd1;

    always_comb begin
      credPlus = credQ[g] + {31'b0, postHit};
      if (hitW && stb.wrCredit)
        credNext[g] = (credPlus > wrData[31:0]) ? credPlus - wrData[31:0] : '0;
      else
        credNext[g] = credPlus;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ[g] <= '0;
        sizeQ[g] <= '0;
        headQ[g] <= '0;
        tailQ[g] <= '0;
        ctrlQ[g] <= '0;
        credQ[g] <= '0;
      end else begin
        if (hitW && stb.wrBase64) baseQ[g] <= wrData;
        if (hitW && stb.wrBaseHi) baseQ[g] <= {wrData[31:0], stageQ};
        if (hitW && stb.wrSize)   sizeQ[g] <= wrData[31:0];
        if (hitW && stb.wrHead)   headQ[g] <= wrData[31:0];
        if (hitW && stb.wrCtrl)   ctrlQ[g] <= wrData[31:0];
        if (postHit)
          tailQ[g] <= (tailInc >= {1'b0, sizeQ[g]}) ? '0 : tailInc[31:0];
        credQ[g] <= credNext[g];
      end
    end
  end

  always_comb begin
    case (stb.rdSel)
      SEL_BASE_LO: rdData = {32'b0, baseQ[sel][31:0]};
      SEL_BASE_HI: rdData = {32'b0, baseQ[sel][63:32]};
      SEL_BASE64:  rdData = baseQ[sel];
      SEL_SIZE:    rdData = {32'b0, sizeQ[sel]};
      SEL_HEAD:    rdData = {32'b0, headQ[sel]};
      SEL_TAIL:    rdData = {32'b0, tailQ[sel]};
      SEL_CTRL:    rdData = {32'b0, ctrlQ[sel]};
      SEL_CREDIT:  rdData = {32'b0, credQ[sel]};
      default:     rdData = '0;
    endcase
  end

  assign ringReq = (stb.wrHead && (wrData[31:0] != tailQ[sel])) ||
                   (stb.wrCredit && (credNext[sel] != '0));
  assign ringVec = vectorOf(stb.ring);
endmodule

// File: rtl/ring_reg_bank.sv
module ring_reg_bank
  import ringbank_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int ADDR_W      = 16,
  parameter int WIN_BASE    = 4096,
  parameter int SLICE_SHIFT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busWide,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [63:0]       busWrData,
  output logic [63:0]       busRdData,
  input  logic              postEn,
  input  logic [7:0]        postRing,
  input  logic              extIrqEn,
  input  logic [7:0]        extIrqVec,
  output logic              irqValid,
  output logic [7:0]        irqVector
);
  localparam int RINGS     = 2 + 2 * NUM_PORTS;
  localparam int VEC_COUNT = 3 + 2 * NUM_PORTS;

  ringStb_t   stb;
  logic       ringReq;
  logic [7:0] ringVec;

  ring_reg_ctrl #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .SLICE_SHIFT(SLICE_SHIFT),
    .RINGS(RINGS), .VEC_COUNT(VEC_COUNT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWide(busWide),
    .busAddr(busAddr), .ringReq(ringReq), .ringVec(ringVec),
    .extIrqEn(extIrqEn), .extIrqVec(extIrqVec), .stb(stb),
    .irqValid(irqValid), .irqVector(irqVector)
  );

  ring_reg_dp #(.RINGS(RINGS)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWrData),
    .postEn(postEn), .postRing(postRing), .rdData(busRdData),
    .ringReq(ringReq), .ringVec(ringVec)
  );
endmodule

// File: rtl/ring_reg_bank_chk.sv
module ring_reg_bank_chk #(
  parameter int NUM_PORTS   = 2,
  parameter int ADDR_W      = 16,
  parameter int WIN_BASE    = 4096,
  parameter int SLICE_SHIFT = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busWide,
  input logic [ADDR_W-1:0] busAddr,
  input logic [63:0]       busRdData,
  input logic              extIrqEn,
  input logic [7:0]        extIrqVec,
  input logic              irqValid,
  input logic [7:0]        irqVector
);
  localparam int VEC_COUNT = 3 + 2 * NUM_PORTS;
  localparam int WIN_END   = WIN_BASE + (2 + 2 * NUM_PORTS) * (1 << SLICE_SHIFT);

  logic outside;
  assign outside = ({1'b0, busAddr} <  (ADDR_W+1)'(WIN_BASE)) ||
                   ({1'b0, busAddr} >= (ADDR_W+1)'(WIN_END));

  AST_OUTSIDE_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    outside |-> (busRdData == 64'd0)); // R1

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busWide |-> (busRdData[63:32] == 32'd0)); // R2

  AST_VECTOR_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (irqVector < 8'(VEC_COUNT))); // R10

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> $past(busWrEn || extIrqEn)); // R9

  AST_EXT_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (extIrqEn && (extIrqVec >= 8'(VEC_COUNT)) && !busWrEn) |=> !irqValid); // R10
endmodule

bind ring_reg_bank ring_reg_bank_chk #(
  .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .SLICE_SHIFT(SLICE_SHIFT)
) uChk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWide(busWide), .busAddr(busAddr),
  .busRdData(busRdData), .extIrqEn(extIrqEn), .extIrqVec(extIrqVec),
  .irqValid(irqValid), .irqVector(irqVector)
);

// File: tb/tb_ring_reg_bank.sv
module tb_ring_reg_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busWide = 1'b0;
  logic [15:0] busAddr = '0;
  logic [63:0] busWrData = '0;
  logic [63:0] busRdData;
  logic        postEn = 1'b0;
  logic [7:0]  postRing = '0;
  logic        extIrqEn = 1'b0;
  logic [7:0]  extIrqVec = '0;
  logic        irqValid;
  logic [7:0]  irqVector;

  int  nRun = 0;
  int  nFail = 0;
  bit  done = 1'b0;
  logic       seenIrq;
  logic [7:0] seenVec;

  always #5 clk = ~clk;

  ring_reg_bank dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWide(busWide),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .postEn(postEn), .postRing(postRing), .extIrqEn(extIrqEn),
    .extIrqVec(extIrqVec), .irqValid(irqValid), .irqVector(irqVector)
  );

  function automatic logic [15:0] ra(input int ring, input int off);
    return 16'(4096 + ring * 32 + off);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d, input logic wide);
    @(negedge clk);
    busAddr = a; busWrData = d; busWide = wide; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0; busWide = 1'b0;
    seenIrq = irqValid; seenVec = irqVector;
  endtask

  task automatic rd(input logic [15:0] a, input logic wide, output logic [63:0] d);
    @(negedge clk);
    busAddr = a; busWide = wide;
    #1 d = busRdData;
    busWide = 1'b0;
  endtask

  task automatic post(input int ring);
    @(negedge clk);
    postEn = 1'b1; postRing = 8'(ring);
    @(posedge clk);
    @(negedge clk);
    postEn = 1'b0;
  endtask

  task automatic test_reset();
    logic [63:0] d;
    check("R12 irqValid after reset", 64'(irqValid), 64'd0);
    rd(ra(0, 0), 1'b1, d); check("R12 ring0 base", d, 64'd0);
    rd(ra(3, 8'h18), 1'b0, d); check("R12 ring3 credits", d, 64'd0);
    rd(ra(5, 8'h14), 1'b0, d); check("R12 ring5 control", d, 64'd0);
  endtask

  task automatic test_window();
    logic [63:0] d;
    wr(16'h0FFC, 64'h1234, 1'b0);
    wr(16'h10C0, 64'h5678, 1'b0);
    rd(16'h10C0, 1'b0, d); check("R1 read above window", d, 64'd0);
    rd(16'h0FFC, 1'b0, d); check("R1 read below window", d, 64'd0);
    rd(ra(5, 0), 1'b1, d); check("R1 last ring untouched", d, 64'd0);
    rd(ra(0, 0), 1'b1, d); check("R1 first ring untouched", d, 64'd0);
  endtask

  task automatic test_base();
    logic [63:0] d;
    wr(ra(2, 0), 64'h11111111, 1'b0);
    rd(ra(2, 0), 1'b1, d); check("R3 low write alone stages only", d, 64'd0);
    wr(ra(2, 4), 64'h22222222, 1'b0);
    rd(ra(2, 0), 1'b1, d); check("R3 assembled base", d, 64'h22222222_11111111);
    rd(ra(2, 4), 1'b0, d); check("R3 high half read", d, 64'h22222222);
    rd(ra(2, 0), 1'b0, d); check("R3 low half read", d, 64'h11111111);
    wr(ra(3, 4), 64'h33, 1'b0);
    rd(ra(3, 0), 1'b1, d); check("R3 staging cleared after commit", d, 64'h33_00000000);
    wr(ra(1, 0), 64'hCAFEF00D, 1'b0);
    wr(ra(5, 4), 64'h55, 1'b0);
    rd(ra(5, 0), 1'b1, d); check("R3 staging shared across rings", d, 64'h55_CAFEF00D);
    rd(ra(1, 0), 1'b1, d); check("R2 staging ring base unchanged", d, 64'd0);
    wr(ra(0, 0), 64'h00000000_0000ABCD, 1'b0);
    wr(ra(4, 0), 64'hA5A5A5A5_5A5A5A5A, 1'b1);
    rd(ra(4, 0), 1'b1, d); check("R4 wide base write", d, 64'hA5A5A5A5_5A5A5A5A);
    rd(ra(4, 4), 1'b0, d); check("R4 wide base high half", d, 64'hA5A5A5A5);
    wr(ra(4, 4), 64'h77, 1'b0);
    rd(ra(4, 0), 1'b1, d); check("R4 wide write keeps staging word", d, 64'h77_0000ABCD);
  endtask

  task automatic test_regs();
    logic [63:0] d;
    wr(ra(1, 8), 64'd8, 1'b0);
    rd(ra(1, 8), 1'b0, d); check("R5 size readback", d, 64'd8);
    wr(ra(0, 8'h14), 64'hFFFF0000_0000DEAD, 1'b0);
    rd(ra(0, 8'h14), 1'b0, d); check("R5 control readback", d, 64'hDEAD);
    rd(ra(1, 8'h14), 1'b0, d); check("R2 neighbour control untouched", d, 64'd0);
    wr(ra(0, 8'h10), 64'd5, 1'b0);
    rd(ra(0, 8'h10), 1'b0, d); check("R5 tail write ignored", d, 64'd0);
    check("R5 tail write raises nothing", 64'(seenIrq), 64'd0);
  endtask

  task automatic test_unimpl();
    logic [63:0] d;
    wr(ra(0, 8'h1C), 64'd7, 1'b0);
    rd(ra(0, 8'h1C), 1'b0, d); check("R11 unimplemented offset reads 0", d, 64'd0);
    rd(ra(0, 8'h02), 1'b0, d); check("R11 unaligned offset reads 0", d, 64'd0);
    wr(ra(1, 8), 64'd99, 1'b1);
    rd(ra(1, 8), 1'b0, d); check("R11 wide write to size ignored", d, 64'd8);
    rd(ra(1, 8), 1'b1, d); check("R11 wide read of size is 0", d, 64'd0);
  endtask

  task automatic test_post();
    logic [63:0] d;
    wr(ra(3, 8), 64'd3, 1'b0);
    post(3);
    rd(ra(3, 8'h10), 1'b0, d); check("R6 tail after one post", d, 64'd1);
    post(3);
    rd(ra(3, 8'h10), 1'b0, d); check("R6 tail after two posts", d, 64'd2);
    post(3);
    rd(ra(3, 8'h10), 1'b0, d); check("R6 tail wraps at size", d, 64'd0);
    rd(ra(3, 8'h18), 1'b0, d); check("R6 credits counted", d, 64'd3);
    post(5);
    rd(ra(5, 8'h10), 1'b0, d); check("R6 size zero keeps tail 0", d, 64'd0);
  endtask

  task automatic test_credit();
    logic [63:0] d;
    wr(ra(3, 8'h18), 64'd1, 1'b0);
    check("R7 irq while credits remain", 64'(seenIrq), 64'd1);
    check("R9 rx ring 3 vector", 64'(seenVec), 64'd4);
    rd(ra(3, 8'h18), 1'b0, d); check("R7 credits after return", d, 64'd2);
    wr(ra(3, 8'h18), 64'd5, 1'b0);
    check("R7 no irq when drained", 64'(seenIrq), 64'd0);
    rd(ra(3, 8'h18), 1'b0, d); check("R7 saturate at zero", d, 64'd0);
  endtask

  task automatic test_head();
    wr(ra(2, 8), 64'd4, 1'b0);
    wr(ra(2, 8'h0C), 64'd0, 1'b0);
    check("R8 head equal tail no irq", 64'(seenIrq), 64'd0);
    wr(ra(2, 8'h0C), 64'd2, 1'b0);
    check("R8 head differs irq", 64'(seenIrq), 64'd1);
    check("R9 tx ring 2 vector", 64'(seenVec), 64'd3);
    wr(ra(0, 8'h0C), 64'd1, 1'b0);
    check("R9 command ring vector", 64'(seenVec), 64'd0);
    wr(ra(1, 8'h0C), 64'd1, 1'b0);
    check("R9 event ring vector", 64'(seenVec), 64'd1);
    wr(ra(5, 8'h0C), 64'd1, 1'b0);
    check("R9 last rx ring vector", 64'(seenVec), 64'd6);
    @(negedge clk);
    check("R9 irq is one cycle pulse", 64'(irqValid), 64'd0);
  endtask

  task automatic ext(input logic [7:0] v);
    @(negedge clk);
    extIrqEn = 1'b1; extIrqVec = v;
    @(posedge clk);
    @(negedge clk);
    extIrqEn = 1'b0;
    seenIrq = irqValid; seenVec = irqVector;
  endtask

  task automatic test_ext();
    ext(8'd6);
    check("R10 ext vector in range issued", 64'(seenIrq), 64'd1);
    check("R10 ext vector value", 64'(seenVec), 64'd6);
    ext(8'd7);
    check("R10 ext vector at count dropped", 64'(seenIrq), 64'd0);
    ext(8'd2);
    check("R10 ext reserved vector issued", 64'(seenVec), 64'd2);
    @(negedge clk);
    extIrqEn = 1'b1; extIrqVec = 8'd5;
    busAddr = ra(0, 8'h0C); busWrData = 64'd9; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0; extIrqEn = 1'b0;
    check("R10 ring request wins", 64'(irqVector), 64'd0);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          nRun++; nFail++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("[TB] %0d tests run, %0d failed", nRun, nFail);
          $finish;
        end
      end
    join_none
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    test_reset();
    test_window();
    test_base();
    test_regs();
    test_unimpl();
    test_post();
    test_credit();
    test_head();
    test_ext();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule